// File: doc/BRIEF.md
# Low-Precision Rounding Unit

This block takes one IEEE single-precision operand per accepted cycle and rounds it to a 16-bit floating-point format chosen per operand: half precision or bfloat16. It drives two results. One is the 16-bit encoding. The other is the same rounded value written back out as an exact single-precision word. Arithmetic that consumes the wide result therefore only ever sees values that the narrow format can hold. This lets a wide datapath stand in for a narrow one.

Per-operand controls set the rounding mode and choose whether subnormal results are kept or flushed to zero. A further control injects a soft error by inverting one significand bit of the result. Stochastic rounding and the fault bit position both draw on an internal 32-bit LFSR. The LFSR is seeded at reset and advances once per accepted operand, so a run can be replayed exactly from the seed.

Top module: `lpr_round_unit`

## Requirements
- R1: `fmt_sel`=0 selects half precision: sign in bit 15, exponent in bits 14:10 with bias 15, fraction in bits 9:0. `fmt_sel`=1 selects bfloat16: sign in bit 15, exponent in bits 14:7 with bias 127, fraction in bits 6:0. A finite input is rounded to a value of the selected format.
- R2: `rnd_mode` 0 rounds to nearest, and exact ties go to the even fraction. Codes 5 to 7 behave the same as code 0.
- R3: `rnd_mode` 1 rounds toward plus infinity, code 2 rounds toward minus infinity and code 3 rounds toward zero. An exact input is never changed.
- R4: `rnd_mode` 4 is stochastic rounding. The 32 discarded bits just below the kept LSB are taken, left-justified; any bits below them are ignored. The result rounds up in magnitude when this value, read as unsigned, is strictly greater than the current LFSR state.
- R5: If a rounded result reaches the all-ones exponent, the block outputs one of two values. It gives infinity under codes 0, 4 and 5 to 7. It gives the largest finite value under code 3, under code 1 for negative values and under code 2 for positive values. Otherwise it gives infinity. The largest finite half value is 65504 (0x7BFF).
- R6: When `sub_en`=1, results below the normal range are denormalised, and the shifted-out bits are rounded under the selected mode. A rounding carry may lift such a result to the smallest normal. For half precision, 2^-24 encodes as 0x0001 and 2^-14 encodes as 0x0400.
- R7: When `sub_en`=0, any result whose final exponent field is zero becomes a zero of the same sign. This test is made after rounding and after fault injection.
- R8: An infinity input gives infinity of the same sign. A NaN input gives a quiet NaN of the same sign: 0x7E00 for half, 0x7FC0 for bfloat16, with bit 15 holding the sign. A zero input gives a zero of the same sign.
- R9: When `flip_en`=1 and the result is finite and has not overflowed, fraction bit (LFSR[31:27] mod F) is inverted. F is 10 for half and 7 for bfloat16.
- R10: `out_wide` is the exact single-precision value of `out_enc`. For bfloat16 it is `{out_enc,16'h0000}`. For half, subnormals are normalised, and infinity or NaN maps to exponent 255 with the fraction shifted left by 13.
- R11: The results appear on the clock edge that samples `in_valid`=1, with `out_valid`=1 for that one cycle. When `in_valid`=0, `out_valid` is 0 on the next cycle and the outputs hold. Reset clears `out_valid`, `out_enc` and `out_wide`.
- R12: The LFSR shifts right in Galois form with tap mask 0x80200003 and loads `SEED` at reset. It advances once on each edge with `in_valid`=1, and each operand uses the state held before that advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid |
| in_data | input | 32 | Single-precision operand |
| fmt_sel | input | 1 | 0 half precision, 1 bfloat16 |
| rnd_mode | input | 3 | Rounding mode code |
| sub_en | input | 1 | 1 keeps subnormals, 0 flushes them |
| flip_en | input | 1 | Inject one significand bit flip |
| out_valid | output | 1 | Result valid |
| out_enc | output | 16 | Rounded 16-bit encoding |
| out_wide | output | 32 | Rounded value as single precision |

## Verification
Directed operands sit exactly on rounding boundaries: exact ties, half-ulp fractions, 65504 and the first value above it, and the smallest half subnormal and values around it. These operands tell the nearest-even rule apart from the directed modes, show overflow going to infinity or to the largest finite value, and show when a subnormal rounds up into the normal range. A repeated quarter-ulp operand under stochastic rounding must round up at a rate near one quarter. This measures the probability itself, apart from the exact LFSR replay. Random operands with exponents focused on each format's range, mixed with random modes, flush and fault settings and idle gaps, are compared against an independent rounding model. This checks that the modes and options combine correctly and that the LFSR advances only on accepted operands.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   localparam int SRC_W      = 32;
   localparam int SRC_EXP_W  = 8;
   localparam int SRC_MANT_W = 23;
   localparam int SRC_BIAS   = 127;
   localparam int ENC_W      = 16;
   localparam int RND_W      = 32;
   localparam int IDX_W      = 5;
   localparam int HALF_EXP_W  = 5;
   localparam int HALF_MANT_W = 10;
   localparam int BF_EXP_W    = 8;
   localparam int BF_MANT_W   = 7;
   localparam int N_FMT       = 2;

   localparam logic [2:0] RM_NEAR  = 3'd0;
   localparam logic [2:0] RM_UP    = 3'd1;
   localparam logic [2:0] RM_DOWN  = 3'd2;
   localparam logic [2:0] RM_ZERO  = 3'd3;
   localparam logic [2:0] RM_STOCH = 3'd4;

   localparam logic [RND_W-1:0] LFSR_TAPS = 32'h8020_0003;
endpackage

// File: rtl/lpr_lfsr.sv
module lpr_lfsr
   import lpr_pkg::*;
#(
   parameter int                W    = RND_W,
   parameter logic [RND_W-1:0]  SEED = 32'hACE1_2024
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [W-1:0] state_o
);
   if (W != RND_W) begin : g_bad_w
      $error("lpr_lfsr: width must match the random word");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("lpr_lfsr: zero seed locks the register");
   end

   logic [W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= SEED[W-1:0];
      else if (adv_i) st_q <= (st_q >> 1) ^ (st_q[0] ? LFSR_TAPS[W-1:0] : '0);
   end

   assign state_o = st_q;

   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0);                                          // R12
   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(st_q));                            // R12
endmodule

// File: rtl/lpr_round_core.sv
module lpr_round_core
   import lpr_pkg::*;
#(
   parameter int EXP_W  = HALF_EXP_W,
   parameter int MANT_W = HALF_MANT_W
) (
   input  logic [SRC_W-1:0] src_i,
   input  logic [2:0]       mode_i,
   input  logic             sub_en_i,
   input  logic             flip_en_i,
   input  logic [RND_W-1:0] rnd_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [ENC_W-1:0] enc_o
);
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int EXP_ALL = (1 << EXP_W) - 1;
   localparam int DROP    = SRC_MANT_W - MANT_W;
   localparam int EXT_W   = SRC_MANT_W + 1 + RND_W;
   localparam int SH_W    = $clog2(EXT_W + 1);
   localparam logic signed [11:0] BIAS_S  = 12'(BIAS);
   localparam logic signed [11:0] EALL_S  = 12'(EXP_ALL);
   localparam logic signed [11:0] DROP_S  = 12'(DROP);
   localparam logic signed [11:0] SRCB_S  = 12'(SRC_BIAS);
   localparam logic signed [11:0] EXT_S   = 12'(EXT_W);

   if (1 + EXP_W + MANT_W != ENC_W) begin : g_bad_fmt
      $error("lpr_round_core: format does not fill the encoding");
   end
   if (MANT_W >= (1 << IDX_W) || DROP < 1) begin : g_bad_mant
      $error("lpr_round_core: fraction width out of range");
   end

   logic                    sgn;
   logic [SRC_EXP_W-1:0]    e8;
   logic [SRC_MANT_W-1:0]   f23;
   logic [SRC_MANT_W:0]     sig;
   logic signed [11:0]      te, texp, shw, rexp;
   logic [SH_W-1:0]         sh;
   logic [EXT_W-1:0]        ext, val;
   logic [MANT_W:0]         kept;
   logic [RND_W-1:0]        disc;
   logic                    lost, inexact, up, to_max;
   logic [MANT_W+1:0]       rsum;
   logic [MANT_W-1:0]       mant, mfin, fmask;
   logic [IDX_W-1:0]        fidx;

   // alignment: place the kept LSB just above a 32-bit discard window
   always_comb begin
      sgn  = src_i[SRC_W-1];
      e8   = src_i[SRC_W-2 -: SRC_EXP_W];
      f23  = src_i[SRC_MANT_W-1:0];
      sig  = {|e8, f23};
      te   = $signed({4'b0, (e8 == '0) ? 8'd1 : e8}) - SRCB_S + BIAS_S;
      texp = (te < 12'sd1) ? 12'sd1 : te;
      shw  = DROP_S + ((te < 12'sd1) ? (12'sd1 - te) : 12'sd0);
      sh   = (shw > EXT_S) ? SH_W'(EXT_W) : shw[SH_W-1:0];
      ext  = {sig, {RND_W{1'b0}}};
      val  = ext >> sh;
      lost = |(ext & ~({EXT_W{1'b1}} << sh));
      kept = val[RND_W +: MANT_W+1];
      disc = val[RND_W-1:0];
      inexact = (|disc) | lost;
   end

   // rounding decision
   always_comb begin
      case (mode_i)
         RM_UP:    up = inexact & ~sgn;
         RM_DOWN:  up = inexact & sgn;
         RM_ZERO:  up = 1'b0;
         RM_STOCH: up = disc > rnd_i;
         default:  up = disc[RND_W-1] & ((|disc[RND_W-2:0]) | lost | kept[0]);
      endcase
      to_max = (mode_i == RM_ZERO) || (mode_i == RM_UP && sgn) || (mode_i == RM_DOWN && !sgn);
   end

   // increment, renormalise, specials, fault and flush
   always_comb begin
      rsum = {1'b0, kept} + {{(MANT_W+1){1'b0}}, up};
      if (rsum[MANT_W+1]) begin
         rexp = texp + 12'sd1;
         mant = '0;
      end else if (rsum[MANT_W]) begin
         rexp = texp;
         mant = rsum[MANT_W-1:0];
      end else begin
         rexp = 12'sd0;
         mant = rsum[MANT_W-1:0];
      end
      fidx  = idx_i % IDX_W'(MANT_W);
      fmask = {{(MANT_W-1){1'b0}}, 1'b1} << fidx;
      mfin  = mant ^ (flip_en_i ? fmask : '0);
      if (!sub_en_i && rexp == 12'sd0) mfin = '0;

      if (&e8) begin
         if (|f23) enc_o = {sgn, {EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};
         else      enc_o = {sgn, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
      end else if (rexp >= EALL_S) begin
         if (to_max) enc_o = {sgn, {(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};
         else        enc_o = {sgn, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
      end else begin
         enc_o = {sgn, rexp[EXP_W-1:0], mfin};
      end
   end

   always_comb begin
      if (!(&e8) && sig == '0 && !flip_en_i)
         AST_ZERO_SIGN: assert (enc_o == {sgn, {(ENC_W-1){1'b0}}});  // R8
   end
endmodule

// File: rtl/lpr_widen.sv
module lpr_widen
   import lpr_pkg::*;
(
   input  logic [ENC_W-1:0] enc_i,
   input  logic             bf16_i,
   output logic [SRC_W-1:0] wide_o
);
   localparam int HM     = HALF_MANT_W;
   localparam int HE     = HALF_EXP_W;
   localparam int PAD    = SRC_MANT_W - HM;
   localparam int REBIAS = SRC_BIAS - ((1 << (HE - 1)) - 1);
   localparam int SUBOFF = REBIAS - HM + 1;

   logic          hs;
   logic [HE-1:0] he;
   logic [HM-1:0] hm;
   logic [4:0]    pos;
   logic [SRC_MANT_W:0] norm;

   always_comb begin
      hs  = enc_i[ENC_W-1];
      he  = enc_i[ENC_W-2 -: HE];
      hm  = enc_i[HM-1:0];
      pos = '0;
      for (int i = 0; i < HM; i++) if (hm[i]) pos = 5'(i);
      norm = (SRC_MANT_W+1)'(hm) << (5'(SRC_MANT_W) - pos);
      if (bf16_i)
         wide_o = {enc_i, {(SRC_W-ENC_W){1'b0}}};
      else if (&he)
         wide_o = {hs, {SRC_EXP_W{1'b1}}, hm, {PAD{1'b0}}};
      else if (he == '0) begin
         if (hm == '0) wide_o = {hs, {(SRC_W-1){1'b0}}};
         else          wide_o = {hs, 8'(SUBOFF) + {3'b0, pos}, norm[SRC_MANT_W-1:0]};
      end else
         wide_o = {hs, {3'b0, he} + 8'(REBIAS), hm, {PAD{1'b0}}};
   end
endmodule

// File: rtl/lpr_round_unit.sv
module lpr_round_unit
   import lpr_pkg::*;
#(
   parameter logic [RND_W-1:0] SEED = 32'hACE1_2024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_data,
   input  logic        fmt_sel,
   input  logic [2:0]  rnd_mode,
   input  logic        sub_en,
   input  logic        flip_en,
   output logic        out_valid,
   output logic [15:0] out_enc,
   output logic [31:0] out_wide
);
   logic [RND_W-1:0] rnd;
   logic [ENC_W-1:0] enc_fmt [N_FMT];
   logic [ENC_W-1:0] enc_sel;
   logic [SRC_W-1:0] wide_sel;
   logic             fmt_q, sub_q;

   lpr_lfsr #(.W(RND_W), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv_i(in_valid), .state_o(rnd)
   );

   for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? HALF_EXP_W  : BF_EXP_W;
      localparam int MW = (g == 0) ? HALF_MANT_W : BF_MANT_W;
      lpr_round_core #(.EXP_W(EW), .MANT_W(MW)) u_core (
         .src_i(in_data), .mode_i(rnd_mode), .sub_en_i(sub_en),
         .flip_en_i(flip_en), .rnd_i(rnd), .idx_i(rnd[RND_W-1 -: IDX_W]),
         .enc_o(enc_fmt[g])
      );
   end

   assign enc_sel = enc_fmt[fmt_sel];

   lpr_widen u_widen (.enc_i(enc_sel), .bf16_i(fmt_sel), .wide_o(wide_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_enc   <= '0;
         out_wide  <= '0;
         fmt_q     <= 1'b0;
         sub_q     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_enc  <= enc_sel;
            out_wide <= wide_sel;
            fmt_q    <= fmt_sel;
            sub_q    <= sub_en;
         end
      end
   end

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                          // R11
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_enc) && $stable(out_wide)); // R11
   AST_BF16_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && fmt_q |-> out_wide == {out_enc, 16'h0000});          // R10
   AST_FLUSH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !sub_q && !fmt_q && out_enc[14:10] == 5'd0 |-> out_enc[9:0] == 10'd0); // R7
   AST_FLUSH_BF16: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !sub_q && fmt_q && out_enc[14:7] == 8'd0 |-> out_enc[6:0] == 7'd0);    // R7
   AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !fmt_q && (&out_enc[14:10]) && (|out_enc[9:0]) |-> out_enc[9]);        // R8
endmodule

// File: tb/sim_lpr_round_unit.sv
`timescale 1ns/1ps
module sim_lpr_round_unit;
   localparam logic [31:0] SEED = 32'h1357_9BDF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        fmt_sel = 1'b0;
   logic [2:0]  rnd_mode = '0;
   logic        sub_en = 1'b1;
   logic        flip_en = 1'b0;
   logic        out_valid;
   logic [15:0] out_enc;
   logic [31:0] out_wide;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] lf = SEED;
   logic [15:0] last_enc = '0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   lpr_round_unit #(.SEED(SEED)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .fmt_sel(fmt_sel), .rnd_mode(rnd_mode), .sub_en(sub_en), .flip_en(flip_en),
      .out_valid(out_valid), .out_enc(out_enc), .out_wide(out_wide)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lf_step(input logic [31:0] s);
      return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
   endfunction

   // reference rounding, built on a normalised value and a quantum exponent
   function automatic logic [15:0] ref_round(input logic [31:0] x, input bit fmt, input logic [2:0] mode,
                                             input bit sub, input bit flip, input logic [31:0] r);
      int M, X, B, emaxf, E2, p, lg, qexp, k, biased, mant, fi;
      longint sig, n, rem;
      logic [31:0] disc;
      bit lost, s, up, inx, tomax;
      M = fmt ? 7 : 10;  X = fmt ? 8 : 5;  B = (1 << (X-1)) - 1;  emaxf = (1 << X) - 1;
      s = x[31];
      if (x[30:23] == 8'hFF) begin
         if (x[22:0] != 0) return fmt ? {s, 15'h7FC0} : {s, 15'h7E00};
         return fmt ? {s, 15'h7F80} : {s, 15'h7C00};
      end
      sig = longint'({x[30:23] != 0, x[22:0]});
      E2  = ((x[30:23] == 0) ? 1 : int'(x[30:23])) - 150;
      disc = 0; lost = 0; n = 0; qexp = 1 - B - M;
      if (sig != 0) begin
         p = 0;
         for (int i = 0; i < 24; i++) if (sig[i]) p = i;
         lg = E2 + p;
         qexp = ((lg < 1 - B) ? 1 - B : lg) - M;
         k = qexp - E2;
         if (k >= 56) begin
            lost = 1;
         end else begin
            n   = sig >> k;
            rem = sig & ((longint'(1) << k) - 1);
            if (k <= 32) disc = 32'(rem << (32 - k));
            else begin
               disc = 32'(rem >> (k - 32));
               lost = (rem & ((longint'(1) << (k - 32)) - 1)) != 0;
            end
         end
      end
      inx = (disc != 0) || lost;
      case (mode)
         3'd1: up = inx && !s;
         3'd2: up = inx && s;
         3'd3: up = 0;
         3'd4: up = disc > r;
         default: up = disc[31] && ((disc[30:0] != 0) || lost || n[0]);
      endcase
      n = n + longint'(up);
      if (n >= (longint'(1) << (M + 1)))   begin biased = qexp + M + B + 1; mant = 0; end
      else if (n >= (longint'(1) << M))    begin biased = qexp + M + B; mant = int'(n) - (1 << M); end
      else                                 begin biased = 0; mant = int'(n); end
      if (biased >= emaxf) begin
         tomax = (mode == 3) || (mode == 1 && s) || (mode == 2 && !s);
         if (tomax) return 16'((int'(s) << 15) | ((emaxf - 1) << M) | ((1 << M) - 1));
         return 16'((int'(s) << 15) | (emaxf << M));
      end
      if (flip) begin
         fi = int'(r[31:27]) % M;
         mant = mant ^ (1 << fi);
      end
      if (!sub && biased == 0) mant = 0;
      return 16'((int'(s) << 15) | (biased << M) | mant);
   endfunction

   function automatic logic [31:0] ref_widen(input logic [15:0] e, input bit fmt);
      int ex, m, sh;
      if (fmt) return {e, 16'h0};
      ex = int'(e[14:10]);  m = int'(e[9:0]);
      if (ex == 31) return {e[15], 8'hFF, e[9:0], 13'h0};
      if (ex == 0) begin
         if (m == 0) return {e[15], 31'h0};
         sh = 0;
         while (m < 1024) begin m = m << 1; sh++; end
         return {e[15], 8'(113 - sh), 10'(m), 13'h0};
      end
      return {e[15], 8'(ex + 112), e[9:0], 13'h0};
   endfunction

   task automatic drive(input logic [31:0] x, input bit f, input logic [2:0] m, input bit sb, input bit fl,
                        input string tag, input bit hard_on, input logic [15:0] hard);
      logic [15:0] e;
      logic [31:0] w;
      e = ref_round(x, f, m, sb, fl, lf);
      w = ref_widen(e, f);
      in_data = x; fmt_sel = f; rnd_mode = m; sub_en = sb; flip_en = fl; in_valid = 1'b1;
      @(posedge clk);
      lf = lf_step(lf);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R11 valid", 32'(out_valid), 32'd1);
      chk(out_enc == e, tag, 32'(out_enc), 32'(e));
      chk(out_wide == w, "R10 widened value", out_wide, w);
      if (hard_on) chk(out_enc == hard, tag, 32'(out_enc), 32'(hard));
      last_enc = e;
   endtask

   task automatic idle_check();
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 idle valid", 32'(out_valid), 32'd0);
      chk(out_enc == last_enc, "R11 idle hold", 32'(out_enc), 32'(last_enc));
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int ups;
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R11 reset valid", 32'(out_valid), 32'd0);
      chk(out_enc == 16'h0, "R11 reset enc", 32'(out_enc), 32'd0);
      chk(out_wide == 32'h0, "R11 reset wide", out_wide, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      drive(32'h3F80_0000, 0, 0, 1, 0, "R1 half one", 1, 16'h3C00);
      drive(32'h3F80_0000, 1, 0, 1, 0, "R1 bf16 one", 1, 16'h3F80);
      drive(32'h3F80_1000, 0, 0, 1, 0, "R2 tie to even down", 1, 16'h3C00);
      drive(32'h3F80_3000, 0, 0, 1, 0, "R2 tie to even up", 1, 16'h3C02);
      drive(32'h3F80_3000, 0, 6, 1, 0, "R2 code 6 as nearest", 1, 16'h3C02);
      drive(32'h3F81_8000, 1, 0, 1, 0, "R2 bf16 tie up", 1, 16'h3F82);
      drive(32'h3F80_8000, 1, 0, 1, 0, "R2 bf16 tie down", 1, 16'h3F80);
      drive(32'h3F80_0800, 0, 1, 1, 0, "R3 toward plus inf", 1, 16'h3C01);
      drive(32'hBF80_0800, 0, 1, 1, 0, "R3 toward plus inf neg", 1, 16'hBC00);
      drive(32'hBF80_0800, 0, 2, 1, 0, "R3 toward minus inf", 1, 16'hBC01);
      drive(32'h3F80_1FFF, 0, 3, 1, 0, "R3 toward zero", 1, 16'h3C00);
      drive(32'h477F_E000, 0, 0, 1, 0, "R5 max finite exact", 1, 16'h7BFF);
      drive(32'h477F_F000, 0, 0, 1, 0, "R5 overflow nearest", 1, 16'h7C00);
      drive(32'h477F_F000, 0, 3, 1, 0, "R5 overflow toward zero", 1, 16'h7BFF);
      drive(32'hC974_2400, 0, 1, 1, 0, "R5 neg overflow up", 1, 16'hFBFF);
      drive(32'hC974_2400, 0, 2, 1, 0, "R5 neg overflow down", 1, 16'hFC00);
      drive(32'h3380_0000, 0, 0, 1, 0, "R6 min subnormal", 1, 16'h0001);
      drive(32'h3300_0000, 0, 0, 1, 0, "R6 half tie to zero", 1, 16'h0000);
      drive(32'h3300_0000, 0, 1, 1, 0, "R6 rounds up to min sub", 1, 16'h0001);
      drive(32'h387F_F000, 0, 0, 1, 0, "R6 carry into min normal", 1, 16'h0400);
      drive(32'h3800_0000, 0, 0, 1, 0, "R6 half subnormal", 1, 16'h0200);
      drive(32'h3380_0000, 0, 0, 0, 0, "R7 flush positive", 1, 16'h0000);
      drive(32'hB800_0000, 0, 0, 0, 0, "R7 flush negative", 1, 16'h8000);
      drive(32'h0040_0000, 1, 0, 0, 0, "R7 bf16 flush", 1, 16'h0000);
      drive(32'h0040_0000, 1, 0, 1, 0, "R6 bf16 subnormal kept", 1, 16'h0040);
      drive(32'hFFC0_0001, 0, 0, 1, 0, "R8 nan half", 1, 16'hFE00);
      drive(32'h7F80_0001, 1, 0, 1, 0, "R8 nan bf16", 1, 16'h7FC0);
      drive(32'hFF80_0000, 0, 0, 1, 0, "R8 neg inf", 1, 16'hFC00);
      drive(32'h8000_0000, 0, 0, 1, 0, "R8 neg zero", 1, 16'h8000);
      drive(32'h3F80_0000, 0, 0, 1, 1, "R9 flip half", 0, 16'h0);
      drive(32'h3F80_0000, 1, 0, 1, 1, "R9 flip bf16", 0, 16'h0);
      drive(32'h7F80_0000, 0, 0, 1, 1, "R9 no flip on inf", 1, 16'h7C00);
      idle_check();
      drive(32'h3F80_0800, 0, 4, 1, 0, "R4 stochastic after idle R12", 0, 16'h0);
      idle_check();

      ups = 0;
      for (int i = 0; i < 400; i++) begin
         drive(32'h3F80_0800, 0, 4, 1, 0, "R4 stochastic replay R12", 0, 16'h0);
         if (out_enc == 16'h3C01) ups++;
      end
      chk(ups > 60 && ups < 140, "R4 round-up rate", 32'(ups), 32'd100);

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] x;
         logic [7:0]  ex;
         bit          f;
         f = 1'($urandom());
         case ($urandom_range(0, 9))
            0:       ex = 8'd0;
            1:       ex = 8'hFF;
            2, 3:    ex = 8'($urandom_range(1, 254));
            default: ex = f ? 8'($urandom_range(1, 10)) : 8'($urandom_range(95, 145));
         endcase
         x = {1'($urandom()), ex, 23'($urandom())};
         if ($urandom_range(0, 3) == 0) x[12:0] = 13'h1000;
         if ($urandom_range(0, 5) == 0) x[22:0] = 23'h0;
         drive(x, f, 3'($urandom_range(0, 7)), 1'($urandom()), ($urandom_range(0, 4) == 0),
               "R1 R3 R4 R5 R6 R7 R9 random", 0, 16'h0);
         if ($urandom_range(0, 3) == 0) idle_check();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule